// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is an I2C bus master whose every bus action is launched by software. A CPU writes a 16-bit control word through a plain register port. A transfer bit in that word fires exactly one action. The other bits of the same word, together with a latched direction flag, decide what that action is: a start followed by an address byte, a byte sent, or a byte received and answered with ACK or NACK. A stop condition can be added to any action. The block has no slave mode and no arbitration, and it does not wait for slaves that stretch the clock.

The block reports each action when it finishes, through sticky status flags. It sets a transmit-empty flag or a receive-full flag, and on a missing acknowledge it also sets a bus-error flag and an ACK-status flag. An interrupt line follows these flags through per-flag enables held in the control word. Both bus lines are driven open-drain: the block only pulls them low through its enable outputs. Each bit on the bus lasts four phases of `PHASE_CLKS` clocks.

Top module: `i2c_cmd_master`

## Requirements
- R1: The register at word address 0 is the control word. It reads back what was last written to it, except that bit 3 always reads 0.
- R2: An action starts only on a control write that sets bit 3 (transfer) and bit 6 (enable) together. A transfer written with bit 6 clear starts nothing. A transfer written while an action is running is dropped.
- R3: A transfer with bit 0 (start) set sends a start condition and then the data register byte, whose bits 7:1 are the target address. The data register's bit 0 is copied into status bit 0 (read mode).
- R4: A transfer without start, while status bit 0 is 0, sends the data register byte on SDA, most significant bit first.
- R5: A transfer without start, while status bit 0 is 1, receives a byte into the data register. The block answers with ACK, or with NACK (SDA released in the ninth bit) when control bit 2 is set.
- R6: With control bit 1 (stop) set, a stop condition follows the byte. Both lines are then released and the bus counts as free.
- R7: A successful action clears status bit 1. It sets status bit 7 after a receive, and status bit 6 after a start or a send.
- R8: A missing acknowledge after a start or a send sets status bits 6, 10 and 1.
- R9: Status bit 2 reads 1 from the launch of an action until a stop has finished. It also reads 1 while the bus is held between actions.
- R10: A write to status word address 1 clears the bits 6, 7 and 10 that are written as 1. Bits 0 and 1 are unaffected by such writes.
- R11: The own-address register (address 2) keeps 7 bits. The data register (address 3) keeps 8 bits. Unused bits read 0.
- R12: The interrupt is high while status bit 6, 7 or 10 is set and its enable is set. The enables are control bit 8, bit 9 and bit 10, in that order.
- R13: A control write with bit 6 and bit 4 (abort) set and bit 3 clear, while the bus is held and idle, sends a stop condition. The action lasts 4*PHASE_CLKS clocks.
- R14: An action lasts 4*PHASE_CLKS*(9 + start + stop) clocks from the write that launched it. Consecutive SCL rising edges within a byte are 4*PHASE_CLKS clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
A wrong phase counter or a wrong bit counter shows up in the status busy bit. That bit then falls one or more clocks away from the expected cycle, and the per-clock comparison against the bench model catches the difference at the first such clock. A corrupted shift register or direction flag shows up at the end of the byte: the bench slave captures a wrong byte, or the received data register reads wrong, or the ACK phase carries the wrong polarity. A wrong status update shows on the interrupt line and in the status word on the clock right after completion.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int PHASE_CLKS = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_oe
);

  localparam int DCW = (PHASE_CLKS > 2) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [DCW-1:0] DLAST = DCW'(PHASE_CLKS - 1);
  localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_OWN = 2'd2, A_DATA = 2'd3;
  localparam int C_START = 0, C_STOP = 1, C_NACK = 2, C_TB = 3, C_MA = 4, C_IUE = 6;
  localparam int C_IE_TE = 8, C_IE_RF = 9, C_IE_BE = 10;

  typedef enum logic [1:0] {SEG_START, SEG_BITS, SEG_STOP} seg_t;

  logic [15:0]    ctl;
  logic [7:0]     dat, sh;
  logic [6:0]     own;
  logic           st_rwm, st_an, st_te, st_rf, st_be;
  logic           active, owned;
  seg_t           seg;
  logic [1:0]     q;
  logic [3:0]     bitn;
  logic [DCW-1:0] dcnt;
  logic           do_start, do_stop, do_read, do_nack, ma_only, ack_ok;

  logic ctl_wr, launch, ma_go, tick, seg_end, done, busy, res_ack;

  assign ctl_wr  = reg_we && reg_addr == A_CTL;
  assign launch  = ctl_wr && reg_wdata[C_IUE] && reg_wdata[C_TB] && !active;
  assign ma_go   = ctl_wr && reg_wdata[C_IUE] && !reg_wdata[C_TB] && reg_wdata[C_MA]
                   && !active && owned;
  assign tick    = active && dcnt == DLAST;
  assign seg_end = tick && q == 2'd3;
  assign done    = seg_end && (seg == SEG_STOP || (seg == SEG_BITS && bitn == 4'd8 && !do_stop));
  assign busy    = active || owned;
  assign res_ack = (seg == SEG_STOP) ? ack_ok : (do_read || !sda_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; owned <= 1'b0; seg <= SEG_START; q <= 2'd0; bitn <= 4'd0;
      dcnt <= '0; sh <= 8'd0; ack_ok <= 1'b0;
      do_start <= 1'b0; do_stop <= 1'b0; do_read <= 1'b0; do_nack <= 1'b0; ma_only <= 1'b0;
    end else if (launch) begin
      active   <= 1'b1;
      seg      <= reg_wdata[C_START] ? SEG_START : SEG_BITS;
      q        <= 2'd0;
      bitn     <= 4'd0;
      dcnt     <= '0;
      sh       <= dat;
      do_start <= reg_wdata[C_START];
      do_stop  <= reg_wdata[C_STOP];
      do_nack  <= reg_wdata[C_NACK];
      do_read  <= !reg_wdata[C_START] && st_rwm;
      ma_only  <= 1'b0;
    end else if (ma_go) begin
      active   <= 1'b1;
      seg      <= SEG_STOP;
      q        <= 2'd0;
      dcnt     <= '0;
      do_start <= 1'b0;
      do_stop  <= 1'b1;
      do_read  <= 1'b0;
      ma_only  <= 1'b1;
    end else if (active) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) q <= q + 2'd1;
      if (seg_end) begin
        case (seg)
          SEG_START: begin seg <= SEG_BITS; bitn <= 4'd0; end
          SEG_BITS: begin
            if (bitn == 4'd8) begin
              ack_ok <= do_read || !sda_i;
              if (do_stop) seg <= SEG_STOP;
            end else begin
              sh   <= {sh[6:0], sda_i};
              bitn <= bitn + 4'd1;
            end
          end
          default: ;
        endcase
      end
      if (done) begin
        active <= 1'b0;
        owned  <= !do_stop;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= 16'd0; dat <= 8'd0; own <= 7'd0;
      st_rwm <= 1'b0; st_an <= 1'b0; st_te <= 1'b0; st_rf <= 1'b0; st_be <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= reg_wdata & 16'hFFF7;
      if (reg_we && reg_addr == A_OWN) own <= reg_wdata[6:0];
      if (reg_we && reg_addr == A_DATA) dat <= reg_wdata[7:0];
      if (launch && reg_wdata[C_START]) st_rwm <= dat[0];
      if (reg_we && reg_addr == A_STAT) begin
        if (reg_wdata[6]) st_te <= 1'b0;
        if (reg_wdata[7]) st_rf <= 1'b0;
        if (reg_wdata[10]) st_be <= 1'b0;
      end
      if (done && !ma_only) begin
        if (res_ack) begin
          st_an <= 1'b0;
          if (do_read) begin
            st_rf <= 1'b1;
            dat   <= sh;
          end else begin
            st_te <= 1'b1;
          end
        end else begin
          st_te <= 1'b1;
          st_be <= 1'b1;
          st_an <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    scl_oe = owned;
    sda_oe = 1'b0;
    if (active) begin
      case (seg)
        SEG_START: begin
          scl_oe = (q == 2'd0) || (q == 2'd3);
          sda_oe = q[1];
        end
        SEG_BITS: begin
          scl_oe = !q[1];
          sda_oe = (bitn == 4'd8) ? (do_read && !do_nack) : (!do_read && !sh[7]);
        end
        default: begin
          scl_oe = (q == 2'd0);
          sda_oe = !q[1];
        end
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = ctl;
      A_STAT:  reg_rdata = {5'd0, st_be, 2'd0, st_rf, st_te, 3'd0, busy, st_an, st_rwm};
      A_OWN:   reg_rdata = {9'd0, own};
      default: reg_rdata = {8'd0, dat};
    endcase
  end

  assign irq = (st_te && ctl[C_IE_TE]) || (st_rf && ctl[C_IE_RF]) || (st_be && ctl[C_IE_BE]);

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && do_stop) |=> (!scl_oe && !sda_oe));

  // R8
  nack_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ma_only && !res_ack) |=> (st_be && st_an && st_te));

  // R12
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_te || st_rf || st_be));

  // R2
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> ($stable(do_start) && $stable(do_read) && $stable(do_stop)));

  // R10
  keep_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STAT && !done) |=> ($stable(st_rwm) && $stable(st_an)));

  // R9
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> reg_addr != A_STAT || reg_rdata[2]);

endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam int P = 3;
  localparam int BITC = 4 * P;
  localparam logic [6:0] SADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd1;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_drive = 1'b0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | s_drive);

  always #4 clk = ~clk;

  i2c_cmd_master #(.PHASE_CLKS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // slave model
  logic s_active = 0, s_addr_phase = 0, s_read = 0, s_match = 0, s_ackslot = 0, s_nacked = 0;
  logic saw_stop = 0, ack_en = 1, s_master_ack = 1;
  int s_bit = 0, s_wr_count = 0;
  logic [7:0] s_sh = 0, s_last_wr = 0;
  logic [7:0] s_rd_byte = 8'h96;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    s_active = 1; s_addr_phase = 1; s_bit = 0; s_read = 0; s_match = 0; s_nacked = 0; s_drive = 0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1 && s_active) begin
    s_active = 0; saw_stop = 1; s_drive = 0;
  end
  always @(posedge scl_w) if (s_active) begin
    if (s_bit < 8) begin
      s_sh = {s_sh[6:0], sda_w};
      s_bit++;
      if (s_bit == 8) begin
        if (s_addr_phase) begin
          s_match = (s_sh[7:1] == SADDR); s_read = s_sh[0]; s_ackslot = 1;
        end else if (!s_read) begin
          s_last_wr = s_sh; s_wr_count++; s_ackslot = 1;
        end else s_ackslot = 0;
      end
    end else begin
      if (!s_ackslot) begin s_master_ack = sda_w; s_nacked = sda_w; end
      s_addr_phase = 0; s_bit = 0;
    end
  end
  always @(negedge scl_w) if (s_active) begin
    if (s_bit == 8) s_drive = s_ackslot && s_match && ack_en;
    else if (s_read && s_match && !s_addr_phase && !s_nacked) s_drive = !s_rd_byte[7 - s_bit];
    else s_drive = 0;
  end

  // SCL period monitor
  int cyc = 0, last_rise = -1, scl_period = 0;
  always @(posedge clk) cyc++;
  always @(posedge scl_w) begin
    if (last_rise >= 0) scl_period = cyc - last_rise;
    last_rise = cyc;
  end

  // reference model
  int m_cnt = 0;
  logic [15:0] m_ctl = 0;
  logic [7:0] m_dat = 0, m_rdbyte = 0;
  logic [6:0] m_own = 0;
  logic m_rwm = 0, m_an = 0, m_te = 0, m_rf = 0, m_be = 0, m_owned = 0;
  logic m_stop = 0, m_read = 0, m_ack = 0, m_ma = 0, m_next_ack = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ctl = 0; m_dat = 0; m_own = 0; m_owned = 0;
      m_rwm = 0; m_an = 0; m_te = 0; m_rf = 0; m_be = 0;
    end else begin
      automatic bit act = (m_cnt > 0);
      automatic bit fin = 0;
      if (act) begin m_cnt--; fin = (m_cnt == 0); end
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            m_ctl = reg_wdata & 16'hFFF7;
            if (reg_wdata[6] && reg_wdata[3] && !act) begin
              m_stop = reg_wdata[1];
              m_read = !reg_wdata[0] && m_rwm;
              if (reg_wdata[0]) m_rwm = m_dat[0];
              m_ack = m_read ? 1'b1 : m_next_ack;
              m_rdbyte = s_rd_byte;
              m_ma = 0;
              m_cnt = BITC * (9 + int'(reg_wdata[0]) + int'(reg_wdata[1]));
            end else if (reg_wdata[6] && !reg_wdata[3] && reg_wdata[4] && !act && m_owned) begin
              m_ma = 1; m_stop = 1; m_cnt = BITC;
            end
          end
          2'd1: begin
            if (reg_wdata[6]) m_te = 0;
            if (reg_wdata[7]) m_rf = 0;
            if (reg_wdata[10]) m_be = 0;
          end
          2'd2: m_own = reg_wdata[6:0];
          default: m_dat = reg_wdata[7:0];
        endcase
      end
      if (fin) begin
        if (!m_ma) begin
          if (m_ack) begin
            m_an = 0;
            if (m_read) begin m_rf = 1; m_dat = m_rdbyte; end else m_te = 1;
          end else begin m_te = 1; m_be = 1; m_an = 1; end
        end
        m_owned = !m_stop;
      end
    end
  end

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctl;
      2'd1: return {5'd0, m_be, 2'd0, m_rf, m_te, 3'd0, (m_cnt > 0) || m_owned, m_an, m_rwm};
      2'd2: return {9'd0, m_own};
      default: return {8'd0, m_dat};
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_te && m_ctl[8]) || (m_rf && m_ctl[9]) || (m_be && m_ctl[10]);
  endfunction

  // per-clock comparison (R9, R12, R14 timing)
  always @(negedge clk) if (rst_n && !finished) begin
    #2;
    checks++;
    if (reg_rdata !== exp_rd(reg_addr) || irq !== exp_irq()) begin
      fails++;
      $display("FAIL R14 per-cycle addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
               reg_addr, reg_rdata, irq, exp_rd(reg_addr), exp_irq());
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    reg_addr = 2'd1;
  endtask

  task automatic wait_idle();
    while (m_cnt != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic act(input logic [15:0] c, input logic ack);
    m_next_ack = ack;
    wr(2'd0, c);
    wait_idle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int wc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_chk("R1 reset ctl", 2'd0, 16'h0000);
    rd_chk("R9 reset status", 2'd1, 16'h0000);
    rd_chk("R11 reset own", 2'd2, 16'h0000);
    rd_chk("R11 reset data", 2'd3, 16'h0000);
    chk("R6 reset lines", {irq, scl_oe, sda_oe}, 3'b000);

    // R1 / R2: TB without enable is stored masked and starts nothing
    wr(2'd0, 16'hFFBF);
    rd_chk("R1 ctl mask", 2'd0, 16'hFFB7);
    rd_chk("R2 no launch without enable", 2'd1, 16'h0000);
    wr(2'd0, 16'h0000);

    // R11
    wr(2'd2, 16'hFFFF);
    rd_chk("R11 own width", 2'd2, 16'h007F);
    wr(2'd3, 16'hABCD);
    rd_chk("R11 data width", 2'd3, 16'h00CD);

    // R3 / R7: start + address write
    wr(2'd3, 16'h0054);
    act(16'h0749, 1'b1);
    rd_chk("R3 R7 status after start", 2'd1, 16'h0044);
    chk("R3 slave address match", s_match, 1'b1);
    chk("R12 irq with te", irq, 1'b1);

    // R12 enable gating
    wr(2'd0, 16'h0040);
    #1 chk("R12 irq gated off", irq, 1'b0);
    wr(2'd0, 16'h0100);
    #1 chk("R12 irq te enable", irq, 1'b1);

    // R10 clear
    wr(2'd1, 16'hFFFF);
    rd_chk("R10 clear te", 2'd1, 16'h0004);

    // R4 / R2 busy drop / R14 period
    wc = s_wr_count;
    wr(2'd3, 16'h00A5);
    m_next_ack = 1'b1;
    wr(2'd0, 16'h0748);
    wr(2'd0, 16'h0748);
    wait_idle();
    chk("R4 byte sent", s_last_wr, 8'hA5);
    chk("R2 second TB dropped", s_wr_count - wc, 1);
    chk("R14 scl period", scl_period, BITC);
    rd_chk("R7 status after send", 2'd1, 16'h0044);

    // R6 send with stop
    wr(2'd1, 16'hFFFF);
    saw_stop = 0;
    wr(2'd3, 16'h003C);
    act(16'h074A, 1'b1);
    chk("R4 byte sent msb first", s_last_wr, 8'h3C);
    rd_chk("R6 bus free", 2'd1, 16'h0040);
    chk("R6 stop seen", saw_stop, 1'b1);
    chk("R6 lines released", {scl_oe, sda_oe}, 2'b00);

    // R3 read address
    wr(2'd1, 16'hFFFF);
    wr(2'd3, 16'h0055);
    act(16'h0749, 1'b1);
    rd_chk("R3 read mode latched", 2'd1, 16'h0045);
    wr(2'd1, 16'hFFFF);

    // R5 receive with ACK
    act(16'h0748, 1'b1);
    rd_chk("R5 received byte", 2'd3, 16'h0096);
    rd_chk("R7 status after receive", 2'd1, 16'h0085);
    chk("R5 master ack", s_master_ack, 1'b0);

    // R10 keeps mode bit
    wr(2'd1, 16'hFFFF);
    rd_chk("R10 mode kept", 2'd1, 16'h0005);

    // R5 receive with NACK + stop
    saw_stop = 0;
    act(16'h074E, 1'b1);
    chk("R5 master nack", s_master_ack, 1'b1);
    rd_chk("R5 status after nack read", 2'd1, 16'h0081);
    chk("R6 stop after read", saw_stop, 1'b1);

    // R8 address not acknowledged
    wr(2'd1, 16'hFFFF);
    wr(2'd3, 16'h0040);
    act(16'h074B, 1'b0);
    rd_chk("R8 address nack flags", 2'd1, 16'h0442);
    chk("R12 irq on bus error", irq, 1'b1);
    wr(2'd1, 16'hFFFF);
    rd_chk("R10 ack status kept", 2'd1, 16'h0002);

    // R13 abort
    wr(2'd3, 16'h0054);
    act(16'h0749, 1'b1);
    wr(2'd1, 16'hFFFF);
    saw_stop = 0;
    wr(2'd0, 16'h0750);
    wait_idle();
    rd_chk("R13 abort frees bus", 2'd1, 16'h0000);
    chk("R13 abort stop", saw_stop, 1'b1);

    // R8 data byte not acknowledged
    act(16'h0749, 1'b1);
    ack_en = 1'b0;
    wr(2'd1, 16'hFFFF);
    wr(2'd3, 16'h0011);
    act(16'h074A, 1'b0);
    rd_chk("R8 data nack flags", 2'd1, 16'h0442);
    ack_en = 1'b1;

    repeat (4) @(negedge clk);
    summary();
  end
endmodule